// File: doc/BRIEF.md
# Genlock Counter Reset Generator

This block decides when the output video timing counters are cleared while the output runs locked to an input reference. It watches three strobes, each one clock cycle wide: the reference line strobe, the reference frame strobe and the output frame-start strobe. From these it produces two reset pulses, one for the output line counter and one for the output frame counter. Each pulse falls in the same cycle as the reference strobe that causes it.

A small host register port sets the behaviour. The line reset normally follows the reference frame strobe. A non-zero line period makes it fire every N reference lines instead. The frame reset fires every M reference frames. The host writes M into a staging register, and the value only takes effect when the host writes the control register. In host mode, periodic frame resets stop until the host pulses a sync bit. The reset then fires at the first reference frame strobe of the following output frame, and periodic counting restarts from that point.

The frame side is a five-state machine:
- FREE_RUN: mode bit low; periodic resets every M frames.
- HOST_IDLE: mode bit high; waiting for a sync pulse; no resets.
- HOST_ARMED: sync pulse seen in the current output frame.
- HOST_WAIT: the next output frame has begun; the reset fires at the first reference frame strobe.
- HOST_RUN: periodic resets counted from the host-started reset.

Transitions:
- Any state goes to FREE_RUN when the mode bit is low.
- FREE_RUN goes to HOST_IDLE when the mode bit is high.
- HOST_IDLE or HOST_RUN goes to HOST_ARMED on a sync falling edge.
- HOST_ARMED goes to HOST_WAIT on an output frame strobe.
- HOST_WAIT goes to HOST_RUN on a reference frame strobe, and this firing takes priority.
- HOST_WAIT goes to HOST_IDLE on an output frame strobe with no reference frame strobe (expiry).

Top module: `gl_reset_gen`

## Requirements
- R1: After reset, all registers read zero. Both reset outputs stay low while no strobes arrive.
- R2: When the line period register (address 0) is zero, `line_rst` equals `ref_frame_stb` in every cycle.
- R3: When the line period N is non-zero, `line_rst` fires on every Nth `ref_line_stb`, counted from the last write of N. Reference frame strobes do not affect it.
- R4: In FREE_RUN with active period M non-zero, `frame_rst` fires on every Mth `ref_frame_stb`, counted from the last control write.
- R5: A write to the staging register (address 1) does not change the frame reset timing. The next control-register write (address 2) copies the staged value into the active period and restarts the frame count.
- R6: In FREE_RUN with active period zero, `frame_rst` never fires.
- R7: In the control register (address 2), bit 0 is the host-mode bit and bit 1 is the sync bit. Both reset to 0. Bits 15:2 always read zero. Address 3 reads zero.
- R8: In host mode, `frame_rst` stays low until a sync falling edge (bit 1 written 1, then 0). It then fires at the first `ref_frame_stb` after the next `out_frame_stb`. Periodic resets every M frames resume, counted from that pulse.
- R9: An armed reset expires if a second `out_frame_stb` arrives before any `ref_frame_stb`. Several sync pulses within one output frame arm a single reset.
- R10: `line_rst` is asserted only in cycles with `ref_line_stb` or `ref_frame_stb`. `frame_rst` is asserted only in cycles with `ref_frame_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_line_stb | input | 1 | Reference line strobe |
| ref_frame_stb | input | 1 | Reference frame strobe |
| out_frame_stb | input | 1 | Output frame-start strobe |
| host_wr | input | 1 | Host write enable |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | REG_W | Host write data |
| host_raddr | input | ADDR_W | Host read address |
| host_rdata | output | REG_W | Host read data (combinational) |
| line_rst | output | 1 | Output line counter reset pulse |
| frame_rst | output | 1 | Output frame counter reset pulse |

## Verification
The bench builds the block with its default 16-bit registers and 2-bit addresses. It drives line periods of 0, 1 and 3 and frame periods of 0, 2 and 3. These small values bring each count wrap, every staged-versus-committed case, arming, expiry and double arming within a few hundred cycles. A behavioural model compares both reset outputs on every clock. Directed pulse counts per phase tie each requirement to a stated number.

// File: rtl/gl_reset_pkg.sv
package gl_reset_pkg;
    localparam int unsigned ADDR_LINE_PERIOD  = 0;
    localparam int unsigned ADDR_FRAME_STAGE  = 1;
    localparam int unsigned ADDR_CTRL         = 2;
    localparam int unsigned CTRL_MODE_BIT     = 0;
    localparam int unsigned CTRL_SYNC_BIT     = 1;

    typedef enum logic [2:0] {
        ST_FREE_RUN   = 3'd0,
        ST_HOST_IDLE  = 3'd1,
        ST_HOST_ARMED = 3'd2,
        ST_HOST_WAIT  = 3'd3,
        ST_HOST_RUN   = 3'd4
    } fr_state_t;
endpackage

// File: rtl/gl_host_regs.sv
module gl_host_regs
    import gl_reset_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  n_val,
    output logic              n_write,
    output logic [REG_W-1:0]  m_act,
    output logic              commit,
    output logic              mode,
    output logic              sync_fall
);
    localparam int CTRL_W = 2;

    logic [REG_W-1:0]  n_q, m_stage_q, m_act_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              sync_d;

    assign n_write = wr_en && (wr_addr == ADDR_W'(ADDR_LINE_PERIOD));
    assign commit  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q       <= '0;
            m_stage_q <= '0;
            m_act_q   <= '0;
            ctrl_q    <= '0;
            sync_d    <= 1'b0;
        end else begin
            sync_d <= ctrl_q[CTRL_SYNC_BIT];
            if (n_write) n_q <= wr_data;
            if (wr_en && (wr_addr == ADDR_W'(ADDR_FRAME_STAGE))) m_stage_q <= wr_data;
            if (commit) begin
                ctrl_q  <= wr_data[CTRL_W-1:0];
                m_act_q <= m_stage_q;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(ADDR_LINE_PERIOD): rd_data = n_q;
            ADDR_W'(ADDR_FRAME_STAGE): rd_data = m_stage_q;
            ADDR_W'(ADDR_CTRL):        rd_data = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
            default:                   rd_data = '0;
        endcase
    end

    assign n_val     = n_q;
    assign m_act     = m_act_q;
    assign mode      = ctrl_q[CTRL_MODE_BIT];
    assign sync_fall = sync_d && !ctrl_q[CTRL_SYNC_BIT];

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ADDR_CTRL)) |-> (rd_data[REG_W-1:CTRL_W] == '0));

    assert_commit_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(m_act));
endmodule

// File: rtl/gl_line_reset.sv
module gl_line_reset #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] n_val,
    input  logic             n_write,
    input  logic             ref_line_stb,
    input  logic             ref_frame_stb,
    output logic             line_rst
);
    logic [CNT_W-1:0] cnt;
    logic             per_line, hit;

    assign per_line = (n_val != '0);
    assign hit      = per_line && ref_line_stb && (cnt == n_val - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (n_write || !per_line) cnt <= '0;
        else if (ref_line_stb)       cnt <= hit ? '0 : cnt + CNT_W'(1);
    end

    always_comb begin
        if (per_line) line_rst = hit;
        else          line_rst = ref_frame_stb;
    end

    assert_line_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |-> (ref_line_stb || ref_frame_stb));

    assert_line_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (n_val != '0) |-> (cnt < n_val));
endmodule

// File: rtl/gl_frame_reset.sv
module gl_frame_reset
    import gl_reset_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] m_act,
    input  logic             commit,
    input  logic             mode,
    input  logic             sync_fall,
    input  logic             ref_frame_stb,
    input  logic             out_frame_stb,
    output logic             frame_rst
);
    fr_state_t        state, state_nx;
    logic [CNT_W-1:0] fcnt;
    logic             periodic_ok, periodic_hit, host_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!mode) begin
            state_nx = ST_FREE_RUN;
        end else begin
            unique case (state)
                ST_FREE_RUN:   state_nx = ST_HOST_IDLE;
                ST_HOST_IDLE:  if (sync_fall) state_nx = ST_HOST_ARMED;
                ST_HOST_RUN:   if (sync_fall) state_nx = ST_HOST_ARMED;
                ST_HOST_ARMED: if (out_frame_stb) state_nx = ST_HOST_WAIT;
                ST_HOST_WAIT: begin
                    if (ref_frame_stb)      state_nx = ST_HOST_RUN;
                    else if (out_frame_stb) state_nx = ST_HOST_IDLE;
                end
                default:       state_nx = ST_FREE_RUN;
            endcase
        end
    end

    always_comb begin
        periodic_ok  = (state == ST_FREE_RUN) || (state == ST_HOST_RUN);
        periodic_hit = periodic_ok && ref_frame_stb && (m_act != '0)
                       && (fcnt == m_act - CNT_W'(1));
        host_hit     = (state == ST_HOST_WAIT) && ref_frame_stb;
        frame_rst    = periodic_hit || host_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    fcnt <= '0;
        else if (commit || host_hit || !periodic_ok) fcnt <= '0;
        else if (ref_frame_stb)        fcnt <= periodic_hit ? '0 : fcnt + CNT_W'(1);
    end

    assert_frame_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst |-> ref_frame_stb);

    assert_host_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOST_IDLE || state == ST_HOST_ARMED) |-> !frame_rst);

    assert_zero_period_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREE_RUN && m_act == '0) |-> !frame_rst);

    assert_wait_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOST_WAIT && out_frame_stb && !ref_frame_stb)
        |=> (state == ST_HOST_IDLE || state == ST_FREE_RUN));
endmodule

// File: rtl/gl_reset_gen.sv
module gl_reset_gen #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_line_stb,
    input  logic              ref_frame_stb,
    input  logic              out_frame_stb,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [REG_W-1:0]  host_rdata,
    output logic              line_rst,
    output logic              frame_rst
);
    logic [REG_W-1:0] n_val, m_act;
    logic             n_write, commit, mode, sync_fall;

    gl_host_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .wr_addr   (host_addr),
        .wr_data   (host_wdata),
        .rd_addr   (host_raddr),
        .rd_data   (host_rdata),
        .n_val     (n_val),
        .n_write   (n_write),
        .m_act     (m_act),
        .commit    (commit),
        .mode      (mode),
        .sync_fall (sync_fall)
    );

    gl_line_reset #(.CNT_W(REG_W)) u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .n_val         (n_val),
        .n_write       (n_write),
        .ref_line_stb  (ref_line_stb),
        .ref_frame_stb (ref_frame_stb),
        .line_rst      (line_rst)
    );

    gl_frame_reset #(.CNT_W(REG_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .m_act         (m_act),
        .commit        (commit),
        .mode          (mode),
        .sync_fall     (sync_fall),
        .ref_frame_stb (ref_frame_stb),
        .out_frame_stb (out_frame_stb),
        .frame_rst     (frame_rst)
    );
endmodule

// File: tb/gl_reset_gen_test.sv
`timescale 1ns/1ps
module gl_reset_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rl = 1'b0, rf = 1'b0, of = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  waddr = '0, raddr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        line_rst, frame_rst;

    int tests = 0, fails = 0;
    int line_cnt = 0, frame_cnt = 0;
    bit done = 0;

    // behavioural model state
    int mn = 0, mstage = 0, mact = 0, lcnt = 0, fcnt = 0, mst = 0;
    bit mmode = 0, msync = 0, msync_d = 0;

    always #2.5 clk = ~clk;

    gl_reset_gen uut (
        .clk(clk), .rst_n(rst_n), .ref_line_stb(rl), .ref_frame_stb(rf),
        .out_frame_stb(of), .host_wr(wr), .host_addr(waddr), .host_wdata(wdata),
        .host_raddr(raddr), .host_rdata(rdata), .line_rst(line_rst), .frame_rst(frame_rst)
    );

    // model update (0 free, 1 host idle, 2 armed, 3 wait, 4 host run)
    always @(posedge clk) begin
        bit fall, hit_host, hit_per, runs;
        int ns;
        if (!rst_n) begin
            mn = 0; mstage = 0; mact = 0; lcnt = 0; fcnt = 0; mst = 0;
            mmode = 0; msync = 0; msync_d = 0;
        end else begin
            fall     = msync_d && !msync;
            runs     = (mst == 0) || (mst == 4);
            hit_host = (mst == 3) && rf;
            hit_per  = runs && rf && mact != 0 && fcnt == mact - 1;
            if (wr && waddr == 0) lcnt = 0;
            else if (mn == 0) lcnt = 0;
            else if (rl) lcnt = (lcnt == mn - 1) ? 0 : lcnt + 1;
            if (wr && waddr == 2) fcnt = 0;
            else if (hit_host || !runs) fcnt = 0;
            else if (rf) fcnt = hit_per ? 0 : fcnt + 1;
            ns = mst;
            if (!mmode) ns = 0;
            else if (mst == 0) ns = 1;
            else if ((mst == 1 || mst == 4) && fall) ns = 2;
            else if (mst == 2 && of) ns = 3;
            else if (mst == 3 && rf) ns = 4;
            else if (mst == 3 && of) ns = 1;
            mst = ns;
            msync_d = msync;
            if (wr) begin
                if (waddr == 0) mn = wdata;
                else if (waddr == 1) mstage = wdata;
                else if (waddr == 2) begin
                    mmode = wdata[0]; msync = wdata[1]; mact = mstage;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit el, ef;
        if (rst_n && !done) begin
            el = (mn == 0) ? rf : (rl && lcnt == mn - 1);
            ef = (((mst == 0) || (mst == 4)) && rf && mact != 0 && fcnt == mact - 1)
                 || (mst == 3 && rf);
            tests++;
            if (line_rst !== el) begin
                fails++;
                $display("FAIL %s line_rst actual %0b expected %0b at %0t",
                         (mn == 0) ? "R2" : "R3", line_rst, el, $time);
            end
            tests++;
            if (frame_rst !== ef) begin
                fails++;
                $display("FAIL %s frame_rst actual %0b expected %0b at %0t",
                         mmode ? "R8" : ((mact == 0) ? "R6" : "R4"), frame_rst, ef, $time);
            end
            if (line_rst) line_cnt++;
            if (frame_rst) frame_cnt++;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(bit l, bit f, bit o);
        rl = l; rf = f; of = o;
        @(posedge clk); #1;
        rl = 0; rf = 0; of = 0;
    endtask

    task automatic hwrite(int a, int d);
        wr = 1; waddr = 2'(a); wdata = 16'(d);
        @(posedge clk); #1;
        wr = 0;
    endtask

    task automatic hread(string req, int a, int exp);
        raddr = 2'(a); #1;
        check(req, int'(rdata), exp);
    endtask

    task automatic frame(int lines, bit with_out);
        if (with_out) step(0, 0, 1);
        for (int i = 0; i < lines; i++) begin
            step(1, 0, 0);
            step(0, 0, 0);
        end
        step(0, 1, 0);
    endtask

    task automatic clear_counts();
        line_cnt = 0; frame_cnt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R10 watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 line_rst in reset", int'(line_rst), 0);
        check("R1 frame_rst in reset", int'(frame_rst), 0);
        rst_n = 1;
        @(posedge clk); #1;
        for (int a = 0; a < 4; a++) hread("R1 register read", a, 0);
        check("R1 line_rst idle", int'(line_rst), 0);

        // R2: N = 0 follows reference frame
        clear_counts();
        for (int k = 0; k < 3; k++) frame(4, 0);
        check("R2 line pulses with N=0", line_cnt, 3);

        // R3: N = 3
        hwrite(0, 3);
        clear_counts();
        for (int k = 0; k < 3; k++) frame(4, 0);
        check("R3 line pulses with N=3", line_cnt, 4);

        // R5/R6: staged M without commit
        hwrite(1, 2);
        clear_counts();
        for (int k = 0; k < 4; k++) frame(2, 0);
        check("R6 no frame reset with active M=0", frame_cnt, 0);
        check("R5 staged M without commit", frame_cnt, 0);
        hwrite(2, 0);
        clear_counts();
        for (int k = 0; k < 4; k++) frame(2, 0);
        check("R4 frame pulses with M=2", frame_cnt, 2);
        hwrite(1, 3);
        clear_counts();
        for (int k = 0; k < 4; k++) frame(2, 0);
        check("R5 uncommitted M=3 keeps period 2", frame_cnt, 2);
        hwrite(2, 0);
        clear_counts();
        for (int k = 0; k < 6; k++) frame(2, 0);
        check("R5 committed M=3", frame_cnt, 2);

        // R8: host mode
        hwrite(2, 1);
        clear_counts();
        for (int k = 0; k < 4; k++) frame(2, 1);
        check("R8 host mode quiet before sync", frame_cnt, 0);
        hwrite(2, 3); hwrite(2, 1);
        step(0, 0, 0); step(0, 0, 0);
        step(0, 0, 1);
        clear_counts();
        step(0, 1, 0);
        check("R8 host-started reset", frame_cnt, 1);
        clear_counts();
        for (int k = 0; k < 3; k++) frame(2, 1);
        check("R8 periodic after host reset", frame_cnt, 1);

        // R9: pulse in the wrong frame expires
        hwrite(2, 3); hwrite(2, 1);
        step(0, 0, 0); step(0, 0, 0);
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 1);
        clear_counts();
        for (int k = 0; k < 3; k++) begin step(0, 0, 0); step(0, 1, 0); end
        check("R9 expired arm gives no reset", frame_cnt, 0);

        // R9: two pulses in one frame arm a single reset
        hwrite(2, 3); hwrite(2, 1); hwrite(2, 3); hwrite(2, 1);
        step(0, 0, 0); step(0, 0, 0);
        clear_counts();
        step(0, 0, 1); step(0, 1, 0); step(0, 0, 1); step(0, 1, 0);
        check("R9 double pulse single reset", frame_cnt, 1);

        // R7: reserved bits
        hwrite(2, 16'hFFFC);
        hread("R7 reserved bits read zero", 2, 0);
        hread("R7 address 3 reads zero", 3, 0);
        hread("R7 staged M readback", 1, 3);
        hread("R7 line period readback", 0, 3);
        hwrite(2, 3);
        hread("R7 control bits readback", 2, 3);
        hwrite(2, 0);

        // R3/R10: N = 1 fires every line, frame strobes ignored
        hwrite(0, 1);
        clear_counts();
        for (int k = 0; k < 5; k++) begin step(1, 0, 0); step(0, 0, 0); end
        step(0, 0, 0);
        check("R3 N=1 pulses every line", line_cnt, 5);
        clear_counts();
        step(0, 1, 0);
        check("R10 frame strobe gives no line reset with N=1", line_cnt, 0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule